// File: doc/BRIEF.md
# ATA PIO Strobe Cycle Generator

This block sits between a simple host I/O request port and a parallel ATA device channel. It decodes legacy IDE I/O addresses, which are either the primary command block and control port or the secondary pair. For each request it claims, it runs one programmed-I/O read or write strobe cycle on the ATA side and drives the chip selects and the three address lines. The host side sees one done pulse per request. A read returns the data word that was captured when the strobe was released.

Timing comes from a 16-bit configuration word written through a direct port. The word holds four things:

- A channel enable and a primary/secondary select.
- One shared fast timing set, made of an IORDY sample point and a recovery time.
- A 3-bit control group for each of the two devices: fast-bank select, IORDY enable, and prefetch/posting enable.
- The prefetch/posting bit is stored but has no effect on strobe timing.

The target device is whichever one the host last named through bit 4 of a write to the drive/head register. Only data-port cycles to a device that selects the fast bank use the programmable set. Every other cycle runs at slow compatible timing. The block also reports the interrupt line number that the channel uses.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset, both strobes and both chip selects are high (inactive), host_done is low, host_rdata is 0, and no cycle is in progress.
- R2: With config bit 15 clear, no request produces a chip select or strobe. Every request still completes with a single done pulse one clock after acceptance, and a read returns 16'hFFFF. Any address outside the active channel's decode completes in the same way.
- R3: Config bit 14 clear selects the primary channel: 0x1F0–0x1F7 and 0x3F6 are decoded and irq_num is 14. Config bit 14 set selects the secondary channel: 0x170–0x177 and 0x376 are decoded and irq_num is 15.
- R4: A command-block access asserts cs0_n low with da = address bits [2:0]. A control-port access asserts cs1_n low with da = 6. Only one chip select is ever low at a time.
- R5: A data-port access (offset 0) to a device whose fast-bank bit is set holds the strobe low for (bits[13:12] + 2) clocks. It then keeps the strobe high for (bits[9:8] + 1) recovery clocks before done.
- R6: Compatible timing is 6 strobe-low clocks and 6 recovery clocks. It applies to a data-port access whose device has its fast-bank bit clear, and to every non-data command register and the control port regardless of the bank bits.
- R7: The device's control group sits at bits [2:0] for device 0 and bits [6:4] for device 1. Within a group, bit 0 is the fast-bank select, bit 1 is the IORDY enable, and bit 2 is prefetch/posting. The device is chosen by bit 4 of the last write to command offset 6, and is 0 after reset.
- R8: When the device's IORDY enable is set and IORDY is low at the last planned strobe-low clock, the strobe stays low until IORDY is seen high. When the enable is clear, IORDY is ignored.
- R9: host_done is a single-clock pulse in the clock that follows the last recovery clock. host_rdata then holds ata_dd_in as sampled at the edge that releases the read strobe.
- R10: A read pulses only ata_dior_n and a write only ata_diow_n, exactly once per claimed request. During a write, ata_dd_oe is high and ata_dd_out carries the write data.
- R11: Timing is captured when a request is accepted. A configuration write during a cycle affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word value |
| host_req | input | 1 | Request; accepted when the block is idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | I/O address |
| host_wdata | input | 16 | Write data |
| host_done | output | 1 | One-clock completion pulse |
| host_rdata | output | 16 | Read data of the last read |
| irq_num | output | 4 | Interrupt line used by the channel (14 or 15) |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_da | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data bus driven value |
| ata_dd_oe | output | 1 | Data bus drive enable |
| ata_dd_in | input | 16 | Data bus sampled value |
| ata_iordy | input | 1 | Device ready |

## Verification
The bench sweeps all sixteen pairs of fast codes and measures strobe width and recovery on the pins. A decoder that confused sample-point codes with clock counts would be off by two, and one that got recovery wrong would be off by one. It aims the fast bank at non-data registers and at the unselected device, where a careless mux would wrongly shorten cycles to a device that must run at compatible speed. It also flips the device through the drive/head register, moves the channel to secondary while addressing primary, and rewrites the configuration in the middle of a strobe; these catch wrong group selection, wrong decode, and timing that is not frozen at acceptance. Finally it holds IORDY low past the sample point with the enable both set and clear, which shows whether the strobe is stretched only when it should be.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 16;
  localparam int CNT_W   = 4;
  localparam int NUM_DEV = 2;
  localparam int GRP_W   = 3;

  localparam logic [ADDR_W-1:0] PRI_CMD = 16'h01F0;
  localparam logic [ADDR_W-1:0] PRI_CTL = 16'h03F6;
  localparam logic [ADDR_W-1:0] SEC_CMD = 16'h0170;
  localparam logic [ADDR_W-1:0] SEC_CTL = 16'h0376;

  localparam logic [CNT_W-1:0] COMPAT_ACT = CNT_W'(6);
  localparam logic [CNT_W-1:0] COMPAT_REC = CNT_W'(6);

  // Configuration word field positions
  localparam int EN_BIT   = 15;
  localparam int SEC_BIT  = 14;
  localparam int ISP_LSB  = 12;
  localparam int RTC_LSB  = 8;
  localparam int DEVHEAD_OFS = 6;
  localparam int DEVSEL_BIT  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ACT, S_REC, S_DONE
  } seq_state_t;

  typedef struct packed {
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] rec;
    logic             iordy_en;
  } timing_t;

  function automatic logic [CNT_W-1:0] fast_active_clks(input logic [1:0] code);
    return CNT_W'(code) + CNT_W'(2);
  endfunction

  function automatic logic [CNT_W-1:0] fast_recovery_clks(input logic [1:0] code);
    return CNT_W'(code) + CNT_W'(1);
  endfunction

  function automatic logic same_block8(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
    return a[ADDR_W-1:3] == base[ADDR_W-1:3];
  endfunction

endpackage

// File: rtl/ata_chan_decode.sv
module ata_chan_decode
  import ata_pio_pkg::*;
(
  input  logic              chan_en,
  input  logic              chan_sec,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              sel_ctl,
  output logic              is_data,
  output logic              is_devhead,
  output logic [2:0]        da,
  output logic [3:0]        irq
);
  logic [ADDR_W-1:0] cmd_base, ctl_addr;
  logic cmd_hit, ctl_hit;

  always_comb begin
    cmd_base   = chan_sec ? SEC_CMD : PRI_CMD;
    ctl_addr   = chan_sec ? SEC_CTL : PRI_CTL;
    cmd_hit    = chan_en && same_block8(addr, cmd_base);
    ctl_hit    = chan_en && (addr == ctl_addr);
    hit        = cmd_hit || ctl_hit;
    sel_ctl    = ctl_hit;
    is_data    = cmd_hit && (addr[2:0] == 3'd0);
    is_devhead = cmd_hit && (addr[2:0] == 3'(DEVHEAD_OFS));
    da         = ctl_hit ? 3'd6 : addr[2:0];
    irq        = chan_sec ? 4'd15 : 4'd14;
  end
endmodule

// File: rtl/ata_timing_sel.sv
module ata_timing_sel
  import ata_pio_pkg::*;
(
  input  logic [DATA_W-1:0] cfg,
  input  logic              dev_sel,
  input  logic              is_data,
  output timing_t           tim
);
  logic [GRP_W-1:0] grp [NUM_DEV];
  logic [GRP_W-1:0] cur;
  logic             use_fast;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_grp
    assign grp[d] = cfg[4*d +: GRP_W];
  end

  always_comb begin
    cur      = grp[dev_sel];
    use_fast = is_data && cur[0];
    tim.act  = use_fast ? fast_active_clks(cfg[ISP_LSB +: 2]) : COMPAT_ACT;
    tim.rec  = use_fast ? fast_recovery_clks(cfg[RTC_LSB +: 2]) : COMPAT_REC;
    tim.iordy_en = cur[1];
  end
endmodule

// File: rtl/ata_strobe_seq.sv
module ata_strobe_seq
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  input  logic              sel_ctl,
  input  logic [2:0]        da_in,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  timing_t           tim,
  input  logic              iordy,
  input  logic [DATA_W-1:0] dd_in,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              cs0_n,
  output logic              cs1_n,
  output logic [2:0]        da,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic              stall,
  output logic              strobe_end
);
  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  timing_t           tim_q;
  logic              wr_q, ctl_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wdata_q;
  logic              act_last, rec_last, cs_on, strobe_on;

  always_comb begin
    act_last   = (state == S_ACT) && (cnt == tim_q.act - CNT_W'(1));
    rec_last   = (state == S_REC) && (cnt == tim_q.rec - CNT_W'(1));
    stall      = act_last && tim_q.iordy_en && !iordy;
    strobe_end = act_last && !stall;
    cs_on      = (state == S_SETUP) || (state == S_ACT) || (state == S_REC);
    strobe_on  = (state == S_ACT);
    idle       = (state == S_IDLE);
    done       = (state == S_DONE);
    cs0_n      = !(cs_on && !ctl_q);
    cs1_n      = !(cs_on && ctl_q);
    da         = da_q;
    dior_n     = !(strobe_on && !wr_q);
    diow_n     = !(strobe_on && wr_q);
    dd_oe      = cs_on && wr_q;
    dd_out     = wdata_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      tim_q   <= '0;
      wr_q    <= 1'b0;
      ctl_q   <= 1'b0;
      da_q    <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cnt <= '0;
          if (hit) begin
            tim_q   <= tim;
            wr_q    <= wr;
            ctl_q   <= sel_ctl;
            da_q    <= da_in;
            wdata_q <= wdata;
            state   <= S_SETUP;
          end else begin
            if (!wr) rdata <= '1;
            state <= S_DONE;
          end
        end
        S_SETUP: begin
          cnt   <= '0;
          state <= S_ACT;
        end
        S_ACT: begin
          if (strobe_end) begin
            if (!wr_q) rdata <= dd_in;
            cnt   <= '0;
            state <= S_REC;
          end else if (!act_last) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_REC: begin
          if (rec_last) state <= S_DONE;
          else          cnt   <= cnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [3:0]        irq_num,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe,
  input  logic [DATA_W-1:0] ata_dd_in,
  input  logic              ata_iordy
);
  logic [DATA_W-1:0] cfg_q;
  logic              dev_sel_q;
  logic              hit, sel_ctl, is_data, is_devhead;
  logic [2:0]        da_dec;
  logic              seq_idle, accept;
  logic              iordy_stall, strobe_end;
  timing_t           tim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      dev_sel_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if (accept && hit && is_devhead && host_wr)
        dev_sel_q <= host_wdata[DEVSEL_BIT];
    end
  end

  assign accept = host_req && seq_idle;

  ata_chan_decode u_dec (
    .chan_en    (cfg_q[EN_BIT]),
    .chan_sec   (cfg_q[SEC_BIT]),
    .addr       (host_addr),
    .hit        (hit),
    .sel_ctl    (sel_ctl),
    .is_data    (is_data),
    .is_devhead (is_devhead),
    .da         (da_dec),
    .irq        (irq_num)
  );

  ata_timing_sel u_tsel (
    .cfg     (cfg_q),
    .dev_sel (dev_sel_q),
    .is_data (is_data),
    .tim     (tim)
  );

  ata_strobe_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .hit        (hit),
    .sel_ctl    (sel_ctl),
    .da_in      (da_dec),
    .wr         (host_wr),
    .wdata      (host_wdata),
    .tim        (tim),
    .iordy      (ata_iordy),
    .dd_in      (ata_dd_in),
    .idle       (seq_idle),
    .done       (host_done),
    .rdata      (host_rdata),
    .cs0_n      (ata_cs0_n),
    .cs1_n      (ata_cs1_n),
    .da         (ata_da),
    .dior_n     (ata_dior_n),
    .diow_n     (ata_diow_n),
    .dd_out     (ata_dd_out),
    .dd_oe      (ata_dd_oe),
    .stall      (iordy_stall),
    .strobe_end (strobe_end)
  );
endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       host_done,
  input logic       host_req,
  input logic       ata_cs0_n,
  input logic       ata_cs1_n,
  input logic       ata_dior_n,
  input logic       ata_diow_n,
  input logic       ata_dd_oe,
  input logic       iordy_stall,
  input logic       strobe_end
);
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));

  a_r4_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_cs0_n && !ata_cs1_n));

  a_r2_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    iordy_stall |=> (!ata_dior_n || !ata_diow_n));

  a_r9_release_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_end |=> (ata_dior_n && ata_diow_n));

  a_r10_oe_not_read: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dd_oe |-> ata_dior_n);
endmodule

bind ata_pio_timer ata_pio_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_done   (host_done),
  .host_req    (host_req),
  .ata_cs0_n   (ata_cs0_n),
  .ata_cs1_n   (ata_cs1_n),
  .ata_dior_n  (ata_dior_n),
  .ata_diow_n  (ata_diow_n),
  .ata_dd_oe   (ata_dd_oe),
  .iordy_stall (iordy_stall),
  .strobe_end  (strobe_end)
);

// File: tb/sim_ata_pio_timer.sv
module sim_ata_pio_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_done;
  logic [15:0] host_rdata;
  logic [3:0]  irq_num;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0]  ata_da;
  logic [15:0] ata_dd_out;
  logic [15:0] ata_dd_in = '0;
  logic        ata_iordy = 1'b1;

  int n_chk = 0, n_bad = 0;

  // results of the last access
  int m_act, m_rec, m_falls, m_cs0, m_cs1, m_da, m_oe_bad;
  logic [15:0] m_rdata;
  bit m_both_low;

  always #4 clk = ~clk;

  ata_pio_timer u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(bit en, bit sec, int isp, int rtc,
                                         int g1, int g0);
    return 16'((int'(en) << 15) | (int'(sec) << 14) | (isp << 12) |
               (rtc << 8) | (g1 << 4) | g0);
  endfunction

  task automatic set_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // hold: strobe-low clocks before IORDY rises (0 = always ready)
  // mid: when set, rewrite config at the first strobe-low clock
  task automatic access(input bit wr, input logic [15:0] addr,
                        input logic [15:0] wd, input int hold,
                        input bit mid, input logic [15:0] midv);
    bit prev_low = 0;
    int guard = 0;
    m_act = 0; m_rec = 0; m_falls = 0; m_cs0 = 0; m_cs1 = 0; m_da = -1;
    m_oe_bad = 0; m_both_low = 0;
    ata_iordy = (hold == 0);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = addr; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    forever begin
      bit low;
      cfg_we = 1'b0;
      if (!ata_cs0_n) m_cs0++;
      if (!ata_cs1_n) m_cs1++;
      if (!ata_dior_n && !ata_diow_n) m_both_low = 1;
      low = !ata_dior_n || !ata_diow_n;
      if (low) begin
        m_act++;
        m_da = int'(ata_da);
        if (wr && (!ata_dd_oe || ata_dd_out != wd)) m_oe_bad++;
        if (!prev_low) m_falls++;
        if (m_act >= hold) ata_iordy = 1'b1;
        if (mid && m_act == 1) begin cfg_we = 1'b1; cfg_wdata = midv; end
      end else if (m_act > 0 && !host_done) begin
        m_rec++;
      end
      prev_low = low;
      if (host_done) begin
        m_rdata = host_rdata;
        break;
      end
      guard++;
      if (guard > 300) begin
        chk(0, "watchdog", guard, 0);
        break;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    ata_iordy = 1'b1;
    @(negedge clk);
    chk(!host_done, "R9 done one clock", int'(host_done), 0);
  endtask

  task automatic rd(input logic [15:0] addr, input int hold);
    access(1'b0, addr, 16'h0, hold, 1'b0, 16'h0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ata_dior_n && ata_diow_n, "R1 strobes idle", int'({ata_dior_n, ata_diow_n}), 3);
    chk(ata_cs0_n && ata_cs1_n, "R1 cs idle", int'({ata_cs0_n, ata_cs1_n}), 3);
    chk(!host_done && host_rdata == 16'h0, "R1 done/rdata", int'(host_rdata), 0);

    // R2 disabled channel
    rd(16'h01F0, 0);
    chk(m_falls == 0 && m_cs0 == 0, "R2 disabled no strobe", m_falls, 0);
    chk(m_rdata == 16'hFFFF, "R2 disabled rdata", int'(m_rdata), 16'hFFFF);

    // R5 R9 sweep of fast codes, device 0, primary
    for (int isp = 0; isp < 4; isp++) begin
      for (int rtc = 0; rtc < 4; rtc++) begin
        set_cfg(mk_cfg(1, 0, isp, rtc, 0, 1));
        ata_dd_in = 16'(16'hA500 + isp * 16 + rtc);
        rd(16'h01F0, 0);
        chk(m_act == isp + 2, "R5 active width", m_act, isp + 2);
        chk(m_rec == rtc + 1, "R5 recovery", m_rec, rtc + 1);
        chk(m_rdata == ata_dd_in, "R9 read data", int'(m_rdata), int'(ata_dd_in));
        chk(m_falls == 1 && !m_both_low, "R10 single read strobe", m_falls, 1);
        chk(m_da == 0 && m_cs1 == 0 && m_cs0 > 0, "R4 data da/cs", m_da, 0);
      end
    end
    chk(irq_num == 4'd14, "R3 primary irq", int'(irq_num), 14);

    // R6 bank clear -> compatible
    set_cfg(mk_cfg(1, 0, 0, 0, 0, 0));
    rd(16'h01F0, 0);
    chk(m_act == 6 && m_rec == 6, "R6 compat data", m_act * 10 + m_rec, 66);

    // R6 R4 fast bank set but non-data register and control port
    set_cfg(mk_cfg(1, 0, 0, 0, 0, 1));
    rd(16'h01F7, 0);
    chk(m_act == 6 && m_rec == 6, "R6 status reg compat", m_act * 10 + m_rec, 66);
    chk(m_da == 7 && m_cs0 > 0 && m_cs1 == 0, "R4 status da", m_da, 7);
    rd(16'h03F6, 0);
    chk(m_act == 6 && m_rec == 6, "R6 ctl port compat", m_act * 10 + m_rec, 66);
    chk(m_da == 6 && m_cs1 > 0 && m_cs0 == 0, "R4 ctl cs1 da", m_da, 6);
    rd(16'h03F7, 0);
    chk(m_falls == 0 && m_rdata == 16'hFFFF, "R2 undecoded 3F7", m_falls, 0);

    // R7 device select: only device 1 fast
    set_cfg(mk_cfg(1, 0, 1, 2, 1, 0));
    access(1'b1, 16'h01F6, 16'h0010, 0, 1'b0, 16'h0);
    chk(m_act == 6 && m_da == 6, "R7 devhead write compat", m_act, 6);
    rd(16'h01F0, 0);
    chk(m_act == 3 && m_rec == 3, "R7 dev1 fast", m_act * 10 + m_rec, 33);
    access(1'b1, 16'h01F6, 16'h00E0, 0, 1'b0, 16'h0);
    rd(16'h01F0, 0);
    chk(m_act == 6 && m_rec == 6, "R7 dev0 compat", m_act * 10 + m_rec, 66);

    // R8 IORDY on device 0, fast isp 0 (2 clocks)
    set_cfg(mk_cfg(1, 0, 0, 0, 0, 3));
    rd(16'h01F0, 5);
    chk(m_act == 5, "R8 stretch by IORDY", m_act, 5);
    rd(16'h01F0, 1);
    chk(m_act == 2, "R8 ready early", m_act, 2);
    set_cfg(mk_cfg(1, 0, 0, 0, 0, 1));
    rd(16'h01F0, 5);
    chk(m_act == 2, "R8 IORDY ignored", m_act, 2);
    set_cfg(mk_cfg(1, 0, 0, 0, 0, 2));
    rd(16'h01F0, 9);
    chk(m_act == 9, "R8 compat stretch", m_act, 9);

    // R10 write
    set_cfg(mk_cfg(1, 0, 2, 1, 0, 1));
    access(1'b1, 16'h01F0, 16'h1234, 0, 1'b0, 16'h0);
    chk(m_act == 4 && m_rec == 2, "R10 write timing", m_act * 10 + m_rec, 42);
    chk(m_oe_bad == 0 && m_falls == 1 && !m_both_low, "R10 write data bus", m_oe_bad, 0);

    // R11 config rewrite mid-cycle
    set_cfg(mk_cfg(1, 0, 3, 3, 0, 1));
    access(1'b0, 16'h01F0, 16'h0, 0, 1'b1, mk_cfg(1, 0, 0, 0, 0, 1));
    chk(m_act == 5 && m_rec == 4, "R11 frozen timing", m_act * 10 + m_rec, 54);
    rd(16'h01F0, 0);
    chk(m_act == 2 && m_rec == 1, "R11 next uses new", m_act * 10 + m_rec, 21);

    // R3 secondary channel
    set_cfg(mk_cfg(1, 1, 1, 1, 0, 1));
    @(negedge clk);
    chk(irq_num == 4'd15, "R3 secondary irq", int'(irq_num), 15);
    rd(16'h0170, 0);
    chk(m_act == 3 && m_rec == 2 && m_cs0 > 0, "R3 secondary data", m_act * 10 + m_rec, 32);
    rd(16'h0376, 0);
    chk(m_cs1 > 0 && m_da == 6, "R3 secondary ctl", m_da, 6);
    rd(16'h01F0, 0);
    chk(m_falls == 0 && m_cs0 == 0 && m_rdata == 16'hFFFF, "R3 primary ignored", m_falls, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule